// File: doc/BRIEF.md
# Serial Configuration Loader for Chained Programmable Devices

This block loads a serial configuration image into one or more programmable devices wired as a chain. On a start pulse it pulls the shared, active-low program line for a set number of system clocks. It then lets the line go and waits until the wired-AND init line reads high, which happens only once every device in the chain has finished its internal reset. After that it takes image bytes from a valid/ready stream and puts them out one bit at a time on a data pin. Each bit gets one pulse of a configuration clock that the block makes by dividing the system clock.

The configuration clock stays low whenever no bit is being sent. It therefore gives no edge before the first data bit and never runs freely while the byte stream stalls. In length mode the block stops after an exact number of data bits, for devices that count clock edges. In stream mode it stops after the byte marked as last. Both modes then send a programmable number of extra clocks with the data pin high. After that the block checks the chain's done input and reports success or an error. If init never rises within its window, it also reports an error.

Top module: `cfg_serial_loader`

## Requirements
- R1: A start pulse while the block is not busy asserts `prog_low_o` (1 = pull program low) for exactly PROG_CYC system clocks and then releases it. While it is asserted, `cclk_o` and `byte_ready_o` stay low.
- R2: After program is released, no configuration clock edge occurs and no byte is requested until `init_i` has been seen high. If init rises within INIT_TMO cycles, the load goes ahead normally, even when init stays low for many cycles.
- R3: If `init_i` is not seen high within INIT_TMO system clocks after program is released, `err_o` is set, no byte is requested and no configuration clock edge is produced.
- R4: Each bit takes 2*DIV_HALF system clocks: first DIV_HALF clocks with `cclk_o` low, then DIV_HALF clocks with it high. `dout_o` changes only while `cclk_o` is low and holds its value across every rising edge.
- R5: With MSB_FIRST=1 (the default), bit 7 of each byte is sent first and bit 0 last.
- R6: `byte_ready_o` is high only while the block waits for the next byte, never while `cclk_o` is high. It drops in the cycle after a byte is accepted (`byte_valid_i` and `byte_ready_o` both high at a clock edge).
- R7: With `len_mode_i`=0 at start, data ends after all 8 bits of the byte accepted with `byte_last_i`=1.
- R8: With `len_mode_i`=1 at start, exactly `len_bits_i` (at least 1) data bits are clocked, which may end partway through a byte. `byte_last_i` has no effect in this mode.
- R9: After the data bits, exactly `trail_clks_i` more rising edges are given with `dout_o`=1. A value of 0 gives none.
- R10: After the trailing clocks, `done_o` is set if `done_i` is seen high within DONE_TMO system clocks. Otherwise `err_o` is set.
- R11: `busy_o` is high from the cycle after start until done or error. `done_o` and `err_o` stay set until the next start. At most one of busy, done and error is high at a time. A start pulse while busy has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle pulse that begins a load |
| len_mode_i | input | 1 | 1 = stop at a bit count, 0 = stop at the last byte (captured at start) |
| len_bits_i | input | LEN_W | Number of data bits in length mode (captured at start) |
| trail_clks_i | input | TRL_W | Number of trailing clocks with data high (captured at start) |
| byte_data_i | input | 8 | Image byte |
| byte_last_i | input | 1 | Marks the final byte in stream mode |
| byte_valid_i | input | 1 | Byte stream valid |
| byte_ready_o | output | 1 | Byte stream ready |
| prog_low_o | output | 1 | 1 = pull the shared program line low, 0 = release it |
| init_i | input | 1 | Wired-AND init line (high = all devices released it) |
| done_i | input | 1 | Chain done line |
| cclk_o | output | 1 | Configuration clock |
| dout_o | output | 1 | Configuration data |
| busy_o | output | 1 | Load in progress |
| done_o | output | 1 | Load finished with done seen |
| err_o | output | 1 | Init or done timeout |

## Verification
The main function is run with several byte images. A mixed image (A5, 3C, 81) in stream mode shows up any bit-order or byte-boundary slip. A length-mode run of 13 bits over an image that flags its first byte as last checks two things: that the block stops partway through a byte, and that the last flag is ignored. Stalls in the byte stream check that the clock stays idle between bytes. An all-zero byte with no trailing clocks checks the zero-trail case. Runs where init never rises or done stays low tell apart the two error paths, and a late init release checks the tolerance window.

// File: rtl/cfg_loader_pkg.sv
package cfg_loader_pkg;
   typedef enum logic [3:0] {
      ST_IDLE,
      ST_PROG,
      ST_WAIT_INIT,
      ST_FETCH,
      ST_SHIFT,
      ST_TRAIL,
      ST_DWAIT,
      ST_FIN,
      ST_ERR
   } ld_state_e;
endpackage

// File: rtl/cfg_sync.sv
module cfg_sync #(
   parameter int STAGES = 2,
   parameter int W      = 1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);
   logic [STAGES-1:0][W-1:0] stg_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg_q <= '0;
      else        stg_q <= {stg_q[STAGES-2:0], d_i};
   end

   assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/cfg_phase_gen.sv
module cfg_phase_gen #(
   parameter int HALF = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run_i,
   output logic cclk_o,
   output logic bit_end_o
);
   localparam int PERIOD = 2 * HALF;
   localparam int PH_W   = $clog2(PERIOD);

   logic [PH_W-1:0] ph_q;

   assign bit_end_o = run_i && (ph_q == PH_W'(PERIOD - 1));
   assign cclk_o    = run_i && (ph_q >= PH_W'(HALF));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  ph_q <= '0;
      else if (!run_i || bit_end_o) ph_q <= '0;
      else                         ph_q <= ph_q + PH_W'(1);
   end
endmodule

// File: rtl/cfg_wait_timer.sv
module cfg_wait_timer #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr_i,
   input  logic             en_i,
   input  logic [CNT_W-1:0] limit_i,
   output logic             hit_o
);
   logic [CNT_W-1:0] cnt_q;

   assign hit_o = en_i && (cnt_q == (limit_i - CNT_W'(1)));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     cnt_q <= '0;
      else if (clr_i) cnt_q <= '0;
      else if (en_i)  cnt_q <= cnt_q + CNT_W'(1);
   end
endmodule

// File: rtl/cfg_serial_loader.sv
module cfg_serial_loader
   import cfg_loader_pkg::*;
#(
   parameter int DIV_HALF    = 2,
   parameter int PROG_CYC    = 8,
   parameter int INIT_TMO    = 1000,
   parameter int DONE_TMO    = 64,
   parameter int LEN_W       = 24,
   parameter int TRL_W       = 8,
   parameter int SYNC_STAGES = 2,
   parameter bit MSB_FIRST   = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic             len_mode_i,
   input  logic [LEN_W-1:0] len_bits_i,
   input  logic [TRL_W-1:0] trail_clks_i,
   input  logic [7:0]       byte_data_i,
   input  logic             byte_last_i,
   input  logic             byte_valid_i,
   output logic             byte_ready_o,
   output logic             prog_low_o,
   input  logic             init_i,
   input  logic             done_i,
   output logic             cclk_o,
   output logic             dout_o,
   output logic             busy_o,
   output logic             done_o,
   output logic             err_o
);
   localparam int BYTE_W  = 8;
   localparam int BIDX_W  = $clog2(BYTE_W);
   localparam int MAX_PI  = (PROG_CYC > INIT_TMO) ? PROG_CYC : INIT_TMO;
   localparam int TMR_MAX = (MAX_PI > DONE_TMO) ? MAX_PI : DONE_TMO;
   localparam int TMR_W   = $clog2(TMR_MAX + 1);
   localparam logic [TMR_W-1:0] LIM_PROG = TMR_W'(PROG_CYC);
   localparam logic [TMR_W-1:0] LIM_INIT = TMR_W'(INIT_TMO);
   localparam logic [TMR_W-1:0] LIM_DONE = TMR_W'(DONE_TMO);

   // elaboration-time parameter checks
   if (DIV_HALF < 1)    begin : g_bad_div   $error("DIV_HALF must be at least 1"); end
   if (PROG_CYC < 1)    begin : g_bad_prog  $error("PROG_CYC must be at least 1"); end
   if (INIT_TMO < 1)    begin : g_bad_init  $error("INIT_TMO must be at least 1"); end
   if (DONE_TMO < 1)    begin : g_bad_done  $error("DONE_TMO must be at least 1"); end
   if (SYNC_STAGES < 2) begin : g_bad_sync  $error("SYNC_STAGES must be at least 2"); end
   if (LEN_W < 1 || TRL_W < 1) begin : g_bad_w $error("counter widths must be positive"); end

   ld_state_e          st_q, st_d;
   logic               mode_q, last_q;
   logic [LEN_W-1:0]   len_q, sent_q;
   logic [TRL_W-1:0]   trail_q;
   logic [BYTE_W-1:0]  sr_q, sr_next;
   logic [BIDX_W-1:0]  bidx_q;
   logic               ser_bit;
   logic [1:0]         line_s;
   logic               init_s, done_s;
   logic               run, bit_end, tmr_en, tmr_hit, tmr_clr;
   logic [TMR_W-1:0]   tmr_lim;
   logic               accept, byte_end, data_end, can_start;

   cfg_sync #(.STAGES(SYNC_STAGES), .W(2)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   ({done_i, init_i}),
      .q_o   (line_s)
   );
   assign init_s = line_s[0];
   assign done_s = line_s[1];

   assign run = (st_q == ST_SHIFT) || (st_q == ST_TRAIL);

   cfg_phase_gen #(.HALF(DIV_HALF)) u_phase (
      .clk       (clk),
      .rst_n     (rst_n),
      .run_i     (run),
      .cclk_o    (cclk_o),
      .bit_end_o (bit_end)
   );

   assign tmr_en  = (st_q == ST_PROG) || (st_q == ST_WAIT_INIT) || (st_q == ST_DWAIT);
   assign tmr_lim = (st_q == ST_PROG) ? LIM_PROG :
                    (st_q == ST_WAIT_INIT) ? LIM_INIT : LIM_DONE;
   assign tmr_clr = (st_q != st_d);

   cfg_wait_timer #(.CNT_W(TMR_W)) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr_i   (tmr_clr),
      .en_i    (tmr_en),
      .limit_i (tmr_lim),
      .hit_o   (tmr_hit)
   );

   // bit-order variant
   if (MSB_FIRST) begin : g_msb
      assign ser_bit = sr_q[BYTE_W-1];
      assign sr_next = {sr_q[BYTE_W-2:0], 1'b0};
   end else begin : g_lsb
      assign ser_bit = sr_q[0];
      assign sr_next = {1'b0, sr_q[BYTE_W-1:1]};
   end

   assign can_start = (st_q == ST_IDLE) || (st_q == ST_FIN) || (st_q == ST_ERR);
   assign accept    = (st_q == ST_FETCH) && byte_valid_i;
   assign byte_end  = (bidx_q == BIDX_W'(BYTE_W - 1));
   assign data_end  = mode_q ? ((sent_q + LEN_W'(1)) == len_q) : (byte_end && last_q);

   always_comb begin
      st_d = st_q;
      unique case (st_q)
         ST_IDLE, ST_FIN, ST_ERR: if (start_i) st_d = ST_PROG;
         ST_PROG:      if (tmr_hit) st_d = ST_WAIT_INIT;
         ST_WAIT_INIT: if (init_s) st_d = ST_FETCH;
                       else if (tmr_hit) st_d = ST_ERR;
         ST_FETCH:     if (byte_valid_i) st_d = ST_SHIFT;
         ST_SHIFT:     if (bit_end) begin
                          if (data_end)      st_d = (trail_q == '0) ? ST_DWAIT : ST_TRAIL;
                          else if (byte_end) st_d = ST_FETCH;
                       end
         ST_TRAIL:     if (bit_end && trail_q == TRL_W'(1)) st_d = ST_DWAIT;
         ST_DWAIT:     if (done_s) st_d = ST_FIN;
                       else if (tmr_hit) st_d = ST_ERR;
         default:      st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= ST_IDLE;
         mode_q  <= 1'b0;
         last_q  <= 1'b0;
         len_q   <= '0;
         sent_q  <= '0;
         trail_q <= '0;
         sr_q    <= '0;
         bidx_q  <= '0;
      end else begin
         st_q <= st_d;
         if (can_start && start_i) begin
            mode_q  <= len_mode_i;
            len_q   <= len_bits_i;
            trail_q <= trail_clks_i;
            sent_q  <= '0;
         end
         if (accept) begin
            sr_q   <= byte_data_i;
            last_q <= byte_last_i;
            bidx_q <= '0;
         end
         if (st_q == ST_SHIFT && bit_end) begin
            sr_q   <= sr_next;
            bidx_q <= bidx_q + BIDX_W'(1);
            sent_q <= sent_q + LEN_W'(1);
         end
         if (st_q == ST_TRAIL && bit_end) trail_q <= trail_q - TRL_W'(1);
      end
   end

   assign byte_ready_o = (st_q == ST_FETCH);
   assign prog_low_o   = (st_q == ST_PROG);
   assign dout_o       = (st_q == ST_SHIFT) ? ser_bit : 1'b1;
   assign busy_o       = !can_start;
   assign done_o       = (st_q == ST_FIN);
   assign err_o        = (st_q == ST_ERR);
endmodule

// File: rtl/cfg_serial_loader_chk.sv
module cfg_serial_loader_chk (
   input logic clk,
   input logic rst_n,
   input logic prog_low,
   input logic cclk,
   input logic dout,
   input logic byte_ready,
   input logic byte_valid,
   input logic busy,
   input logic done,
   input logic err
);
   AST_NO_CLK_IN_PROG: assert property (@(posedge clk) disable iff (!rst_n)
      prog_low |-> (!cclk && !byte_ready)); // R1
   AST_DATA_STABLE_AT_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cclk) |-> $stable(dout)); // R4
   AST_READY_CLOCK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      byte_ready |-> !cclk); // R6
   AST_READY_DROPS_ON_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_ready && byte_valid) |=> !byte_ready); // R6
   AST_STATUS_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({busy, done, err})); // R11
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!cclk && !prog_low && !byte_ready)); // R11
endmodule

bind cfg_serial_loader cfg_serial_loader_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .prog_low   (prog_low_o),
   .cclk       (cclk_o),
   .dout       (dout_o),
   .byte_ready (byte_ready_o),
   .byte_valid (byte_valid_i),
   .busy       (busy_o),
   .done       (done_o),
   .err        (err_o)
);

// File: tb/cfg_serial_loader_test.sv
module cfg_serial_loader_test;
   localparam int DIV_HALF = 2;
   localparam int PROG_CYC = 8;
   localparam int INIT_TMO = 1000;
   localparam int DONE_TMO = 64;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic        len_mode_i = 1'b0;
   logic [23:0] len_bits_i = '0;
   logic [7:0]  trail_clks_i = '0;
   logic [7:0]  byte_data_i = '0;
   logic        byte_last_i = 1'b0;
   logic        byte_valid_i = 1'b0;
   logic        init_i = 1'b1;
   logic        done_i = 1'b0;
   logic        byte_ready_o, prog_low_o, cclk_o, dout_o, busy_o, done_o, err_o;

   always #10 clk = ~clk;

   cfg_serial_loader uut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .len_mode_i(len_mode_i),
      .len_bits_i(len_bits_i), .trail_clks_i(trail_clks_i),
      .byte_data_i(byte_data_i), .byte_last_i(byte_last_i),
      .byte_valid_i(byte_valid_i), .byte_ready_o(byte_ready_o),
      .prog_low_o(prog_low_o), .init_i(init_i), .done_i(done_i),
      .cclk_o(cclk_o), .dout_o(dout_o), .busy_o(busy_o),
      .done_o(done_o), .err_o(err_o));

   int checks = 0;
   int fails  = 0;
   int cyc = 0;
   bit finished = 0;

   // reference model state
   bit        exp_q[$];
   logic [7:0] src_q[$];
   int  src_last = 0;
   int  feed_gap = 0;
   bit  abort = 0;
   int  init_delay = 0;
   int  since_rel = 0;
   bit  init_ok = 0;
   bit  done_ok = 0;
   int  exp_total = 0;
   int  rises = 0;
   int  prog_run = 0;
   int  prog_w = 0;
   int  prog_cnt = 0;
   int  hi_run = 0;
   logic cclk_prev = 1'b0;
   logic dout_prev = 1'b1;

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   endtask

   // per-cycle monitor and device model, sampled away from the active edge
   always @(negedge clk) begin
      if (rst_n && !finished) begin
         cyc++;
         if (cyc > 150000) begin
            checks++; fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            finished = 1;
            finish_run();
         end
         // program pulse width, R1
         if (prog_low_o) prog_run++;
         else if (prog_run != 0) begin
            prog_w = prog_run; prog_cnt++; prog_run = 0;
         end
         // device chain: hold init low during and after program
         if (prog_low_o) begin
            init_i = 1'b0; since_rel = 0; init_ok = 0;
         end else if (!init_i && init_delay >= 0) begin
            since_rel++;
            if (since_rel >= init_delay) init_i = 1'b1;
         end
         if (init_i) init_ok = 1;
         // clock edges against the expected bit queue
         if (cclk_o && !cclk_prev) begin
            rises++;
            if (!init_ok) chk(0, "R2 edge before init high", rises, 0);
            chk(dout_o == dout_prev, "R4 data stable at rise", dout_o, dout_prev);
            if (exp_q.size() == 0) chk(0, "R8/R9 extra clock edge", rises, exp_total);
            else begin
               automatic bit e = exp_q.pop_front();
               chk(dout_o == e, "R5/R7/R8/R9 bit value", dout_o, e);
            end
         end
         if (cclk_o) hi_run++;
         else if (hi_run != 0) begin
            chk(hi_run == DIV_HALF, "R4 high phase length", hi_run, DIV_HALF);
            hi_run = 0;
         end
         if (byte_ready_o && (cclk_o || prog_low_o))
            chk(0, "R6 ready while clocking", 1, 0);
         done_i = done_ok && (rises >= exp_total) && !prog_low_o;
         cclk_prev = cclk_o;
         dout_prev = dout_o;
      end
   end

   task automatic feed();
      for (int i = 0; i < src_q.size(); i++) begin
         bit taken = 0;
         if (abort) break;
         byte_data_i  = src_q[i];
         byte_last_i  = (i == src_last);
         byte_valid_i = 1'b1;
         while (!taken && !abort) begin
            taken = byte_ready_o;
            @(negedge clk);
         end
         byte_valid_i = 1'b0;
         for (int g = 0; g < feed_gap; g++) @(negedge clk);
      end
      byte_valid_i = 1'b0;
   endtask

   // runs one load; returns cycles from start to done/error
   task automatic run_cfg(input bit lmode, input int lbits, input int trl,
                          input int idelay, input bit dok, output int took);
      int nbits;
      int t0;
      exp_q.delete();
      nbits = 0;
      if (lmode) begin
         for (int i = 0; i < lbits; i++)
            exp_q.push_back(src_q[i / 8][7 - (i % 8)]);
         nbits = lbits;
      end else begin
         for (int b = 0; b <= src_last; b++)
            for (int k = 7; k >= 0; k--) exp_q.push_back(src_q[b][k]);
         nbits = 8 * (src_last + 1);
      end
      for (int i = 0; i < trl; i++) exp_q.push_back(1'b1);
      exp_total = nbits + trl;
      init_delay = idelay;
      done_ok = dok;
      rises = 0;
      abort = 0;
      @(negedge clk);
      len_mode_i = lmode;
      len_bits_i = 24'(lbits);
      trail_clks_i = 8'(trl);
      start_i = 1'b1;
      t0 = cyc;
      @(negedge clk);
      start_i = 1'b0;
      fork feed(); join_none
      while (!done_o && !err_o) @(negedge clk);
      took = cyc - t0;
      abort = 1;
      @(negedge clk);
      byte_valid_i = 1'b0;
   endtask

   initial begin
      int took;
      int pc;
      repeat (3) @(negedge clk);
      // R11 reset state
      chk(!busy_o && !done_o && !err_o, "R11 reset status idle", {busy_o, done_o, err_o}, 0);
      chk(!prog_low_o && !cclk_o && !byte_ready_o, "R1 reset outputs quiet",
          {prog_low_o, cclk_o, byte_ready_o}, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // stream mode, mixed image, late init release, start pulse while busy
      src_q = '{8'hA5, 8'h3C, 8'h81}; src_last = 2; feed_gap = 0;
      pc = prog_cnt;
      fork
         begin
            repeat (40) @(negedge clk);
            start_i = 1'b1; @(negedge clk); start_i = 1'b0; // R11 ignored while busy
         end
      join_none
      run_cfg(0, 0, 3, 120, 1, took);
      chk(done_o && !err_o, "R7 stream load done", done_o, 1);
      chk(rises == 27, "R9 stream edge count", rises, 27);
      chk(exp_q.size() == 0, "R7 all bits clocked", exp_q.size(), 0);
      chk(prog_w == PROG_CYC, "R1 program pulse width", prog_w, PROG_CYC);
      chk(prog_cnt == pc + 1, "R11 start while busy ignored", prog_cnt - pc, 1);
      repeat (10) @(negedge clk);
      chk(done_o && !busy_o, "R11 done held", done_o, 1);
      chk(took > 120 + PROG_CYC, "R2 init wait tolerated", took, 120 + PROG_CYC);

      // length mode, stops mid-byte, early last flag ignored
      src_q = '{8'hF0, 8'h0F, 8'hAA, 8'h55}; src_last = 0;
      run_cfg(1, 13, 5, 4, 1, took);
      chk(done_o, "R8 length load done", done_o, 1);
      chk(rises == 18, "R8 length edge count", rises, 18);
      chk(exp_q.size() == 0, "R8 all bits clocked", exp_q.size(), 0);

      // stalls between bytes, clock idles
      src_q = '{8'h69, 8'hC3}; src_last = 1; feed_gap = 7;
      run_cfg(0, 0, 2, 3, 1, took);
      chk(done_o && rises == 18, "R6 stalled stream edge count", rises, 18);
      feed_gap = 0;

      // zero trailing clocks
      src_q = '{8'h00}; src_last = 0;
      run_cfg(0, 0, 0, 2, 1, took);
      chk(done_o && rises == 8, "R9 zero trail edge count", rises, 8);

      // done never seen
      src_q = '{8'h5A}; src_last = 0;
      run_cfg(0, 0, 3, 2, 0, took);
      chk(err_o && !done_o, "R10 done timeout error", err_o, 1);
      chk(rises == 11, "R10 edges before done check", rises, 11);

      // init never released
      src_q = '{8'hFF}; src_last = 0;
      run_cfg(0, 0, 3, -1, 1, took);
      chk(err_o, "R3 init timeout error", err_o, 1);
      chk(rises == 0, "R3 no clock edges", rises, 0);
      chk(took >= PROG_CYC + INIT_TMO, "R3 timeout not early", took, PROG_CYC + INIT_TMO);
      repeat (5) @(negedge clk);
      chk(err_o && !busy_o, "R11 error held", err_o, 1);

      // recovery after error
      src_q = '{8'h81}; src_last = 0;
      run_cfg(0, 0, 1, 1, 1, took);
      chk(done_o && !err_o && rises == 9, "R11 restart after error", rises, 9);

      finished = 1;
      finish_run();
   end
endmodule